// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one word-sized atomic memory operation at a time against a simple single-port memory. A caller hands it a 32-bit instruction word, a target address taken from the first source register and an operand taken from the second source register. Alongside these comes one permission bit that stands for the combined read-and-write access check on that address. The block decodes the instruction and validates the request. It then reads the addressed word, combines it with the operand using one of nine operations and stores the result back. The caller gets the word as it was before the update, together with the destination register index.

A request can end in one of three ways, each a one-cycle pulse. A completion returns the old memory word and the destination index. An illegal-instruction pulse means the word is not a supported atomic operation. A fault pulse carries a cause code and the offending address. On the illegal and fault paths the destination register is never written, and memory is either untouched or only read. The command side is a valid/ready pair, and a new command is taken only when the block is idle.

Top module: `rmwAtomicUnit`

## Requirements
- R1: A command is legal only when bits [6:0] are 0101111, bits [14:12] are 010 and bits [31:27] hold one of the nine operation codes listed in R2. Any other word gives a single illegal pulse, with no memory read or write and no completion. Illegal decode takes priority over the misaligned and permission faults.
- R2: The word written back is a function of the operand (rs2) and the word read (mem), selected by bits [31:27]: 00000 gives rs2+mem modulo 2^32, 00001 gives rs2, 00100 gives rs2 XOR mem, 01100 gives rs2 AND mem, 01000 gives rs2 OR mem.
- R3: The min/max codes are 10000, 10100, 11000 and 11100. They write the smaller operand when bit 29 is 0 and the larger when bit 29 is 1. The comparison is unsigned when bits [31:30] are 11 and two's-complement signed otherwise.
- R4: On completion, doneValid is high for exactly one cycle, doneData holds the memory word from before the update and doneRd holds instruction bits [11:7].
- R5: A legal, aligned and permitted command first holds memRdReq with memAddr equal to the command address until memRdValid or memRdErr. It then holds memWrReq with the computed data and an all-ones byte mask until memWrReady. Completion follows in the cycle after the write is accepted.
- R6: If the permission bit sampled with the command is 0, the block gives a fault with cause 15 and faultAddr equal to the command address, and issues no memory request.
- R7: A memory read that returns memRdErr gives a fault with cause 15 and faultAddr equal to the command address, and no write is issued.
- R8: A command address with bits [1:0] not zero gives a fault with cause 6 and no memory request. This check ranks above the permission check.
- R9: cmdReady is high only while idle. It is low from the cycle after acceptance through the cycle of the completion, illegal or fault pulse. Each command yields exactly one of those three pulses.
- R10: While reset is held and straight after it, cmdReady is 1 and no memory request or outcome pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Block idle and taking a command |
| cmdInstr | input | 32 | Instruction word |
| cmdAddr | input | ADDR_W | Target address (rs1 value) |
| cmdOperand | input | DATA_W | Operand (rs2 value) |
| cmdPermOk | input | 1 | Combined read and write permission for cmdAddr |
| memRdReq | output | 1 | Memory read request |
| memWrReq | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Memory word address |
| memWrData | output | DATA_W | Data to store |
| memWrMask | output | DATA_W/8 | Byte enables of the store |
| memRdValid | input | 1 | Read data returned |
| memRdErr | input | 1 | Read returned an error |
| memRdData | input | DATA_W | Read data |
| memWrReady | input | 1 | Write accepted |
| doneValid | output | 1 | Completion pulse |
| doneRd | output | 5 | Destination register index |
| doneData | output | DATA_W | Memory word before the update |
| illegalPulse | output | 1 | Unsupported instruction pulse |
| faultValid | output | 1 | Fault pulse |
| faultCause | output | CAUSE_W | Fault cause code |
| faultAddr | output | ADDR_W | Faulting address |

## Verification
The bench builds the block with its defaults: 32-bit address and data and a 5-bit cause field. At these widths the operand pairs 0x80000000/0x7FFFFFFF and 0xFFFFFFFE/0x00000001 sit on both sides of the sign boundary, so signed and unsigned min/max must pick opposite operands. Memory response latency is varied from zero to three cycles, which checks that the requests are held and that the read data is captured only on its valid cycle. Directed cases cover the fault priority order and the read-error path, where memory must remain unchanged.

// File: rtl/rmwAtomicPkg.sv
package rmwAtomicPkg;

  localparam logic [6:0] OPC_ATOMIC = 7'b0101111;
  localparam logic [2:0] WIDTH_WORD = 3'b010;

  localparam logic [4:0] OP_ADD  = 5'b00000;
  localparam logic [4:0] OP_SWAP = 5'b00001;
  localparam logic [4:0] OP_XOR  = 5'b00100;
  localparam logic [4:0] OP_AND  = 5'b01100;
  localparam logic [4:0] OP_OR   = 5'b01000;
  localparam logic [4:0] OP_MIN  = 5'b10000;
  localparam logic [4:0] OP_MAX  = 5'b10100;
  localparam logic [4:0] OP_MINU = 5'b11000;
  localparam logic [4:0] OP_MAXU = 5'b11100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_WRITE, ST_DONE, ST_ILLEGAL, ST_FAULT
  } seqState_t;

  typedef struct packed {
    logic captureCmd;
    logic captureRead;
  } dpStrobe_t;

  typedef struct packed {
    logic legal;
    logic misaligned;
    logic permOk;
  } dpStatus_t;

  function automatic logic opKnown(input logic [4:0] f5);
    case (f5)
      OP_ADD, OP_SWAP, OP_XOR, OP_AND, OP_OR,
      OP_MIN, OP_MAX, OP_MINU, OP_MAXU: opKnown = 1'b1;
      default:                          opKnown = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rmwAlu.sv
module rmwAlu
  import rmwAtomicPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [4:0]        opSel,
  input  logic [DATA_W-1:0] rs2Val,
  input  logic [DATA_W-1:0] memVal,
  output logic [DATA_W-1:0] result
);

  logic unsignedCmp;
  logic pickMax;
  logic rs2Less;

  assign unsignedCmp = (opSel[4:3] == 2'b11);
  assign pickMax     = opSel[2];
  assign rs2Less     = unsignedCmp ? (rs2Val < memVal)
                                   : ($signed(rs2Val) < $signed(memVal));

  always_comb begin
    case (opSel)
      OP_ADD:  result = rs2Val + memVal;
      OP_SWAP: result = rs2Val;
      OP_XOR:  result = rs2Val ^ memVal;
      OP_AND:  result = rs2Val & memVal;
      OP_OR:   result = rs2Val | memVal;
      default: result = (pickMax ^ rs2Less) ? rs2Val : memVal;
    endcase
  end

endmodule

// File: rtl/rmwDatapath.sv
module rmwDatapath
  import rmwAtomicPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_MISALIGN = 6,
  parameter logic [CAUSE_W-1:0] CAUSE_ACCESS   = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  output dpStatus_t           status,
  input  logic [31:0]         cmdInstr,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0]   cmdOperand,
  input  logic                cmdPermOk,
  input  logic [DATA_W-1:0]   memRdData,
  input  logic                memWrReq,
  input  logic                memWrReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrMask,
  output logic [4:0]          doneRd,
  output logic [DATA_W-1:0]   doneData,
  output logic [CAUSE_W-1:0]  faultCause,
  output logic [ADDR_W-1:0]   faultAddr
);

  localparam int STRB_W  = DATA_W / 8;
  localparam int ALIGN_W = $clog2(STRB_W);

  logic [4:0]        opReg;
  logic [4:0]        rdReg;
  logic              legalReg;
  logic              permReg;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] operandReg;
  logic [DATA_W-1:0] oldReg;
  logic [DATA_W-1:0] newReg;
  logic [DATA_W-1:0] aluOut;
  logic              cmdLegal;
  logic              unusedFields;

  assign cmdLegal = (cmdInstr[6:0] == OPC_ATOMIC) &&
                    (cmdInstr[14:12] == WIDTH_WORD) &&
                    opKnown(cmdInstr[31:27]);
  assign unusedFields = ^cmdInstr[26:15];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg      <= '0;
      rdReg      <= '0;
      legalReg   <= 1'b0;
      permReg    <= 1'b0;
      addrReg    <= '0;
      operandReg <= '0;
    end else if (strobe.captureCmd) begin
      opReg      <= cmdInstr[31:27];
      rdReg      <= cmdInstr[11:7];
      legalReg   <= cmdLegal;
      permReg    <= cmdPermOk;
      addrReg    <= cmdAddr;
      operandReg <= cmdOperand;
    end
  end

  rmwAlu #(.DATA_W(DATA_W)) u_alu (
    .opSel  (opReg),
    .rs2Val (operandReg),
    .memVal (memRdData),
    .result (aluOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oldReg <= '0;
      newReg <= '0;
    end else if (strobe.captureRead) begin
      oldReg <= memRdData;
      newReg <= aluOut;
    end
  end

  assign status.legal      = legalReg;
  assign status.misaligned = (addrReg[ALIGN_W-1:0] != '0);
  assign status.permOk     = permReg;

  assign memAddr    = addrReg;
  assign memWrData  = newReg;
  assign memWrMask  = {STRB_W{1'b1}};
  assign doneRd     = rdReg;
  assign doneData   = oldReg;
  assign faultAddr  = addrReg;
  assign faultCause = status.misaligned ? CAUSE_MISALIGN : CAUSE_ACCESS;

  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && !memWrReady |=> $stable(memWrData) && $stable(memAddr)) // R5
    else $error("write data moved while waiting for ready");

  AST_OLD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |=> $stable(oldReg)) // R4
    else $error("old value changed after the read");

endmodule

// File: rtl/rmwCtrl.sv
module rmwCtrl
  import rmwAtomicPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdValid,
  output logic      cmdReady,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  input  logic      memRdValid,
  input  logic      memRdErr,
  input  logic      memWrReady,
  output logic      memRdReq,
  output logic      memWrReq,
  output logic      doneValid,
  output logic      illegalPulse,
  output logic      faultValid
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (cmdValid) stateNext = ST_CHECK;
      ST_CHECK: begin
        if (!status.legal)          stateNext = ST_ILLEGAL;
        else if (status.misaligned) stateNext = ST_FAULT;
        else if (!status.permOk)    stateNext = ST_FAULT;
        else                        stateNext = ST_READ;
      end
      ST_READ: begin
        if (memRdErr)        stateNext = ST_FAULT;
        else if (memRdValid) stateNext = ST_WRITE;
      end
      ST_WRITE: if (memWrReady) stateNext = ST_DONE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign cmdReady     = (state == ST_IDLE);
  assign memRdReq     = (state == ST_READ);
  assign memWrReq     = (state == ST_WRITE);
  assign doneValid    = (state == ST_DONE);
  assign illegalPulse = (state == ST_ILLEGAL);
  assign faultValid   = (state == ST_FAULT);

  assign strobe.captureCmd  = cmdReady && cmdValid;
  assign strobe.captureRead = memRdReq && memRdValid && !memRdErr;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneValid, illegalPulse, faultValid})) // R9
    else $error("more than one outcome pulse");

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !memRdReq && !memWrReq) // R9
    else $error("memory request while idle");

  AST_NO_REQ_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdReq && memWrReq)) // R5
    else $error("read and write requested together");

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrReq) |-> $past(memRdValid && !memRdErr)) // R7
    else $error("write without a clean read");

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(memWrReq && memWrReady)) // R5
    else $error("completion without accepted write");

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdValid && !memRdErr |=> memRdReq) // R5
    else $error("read request dropped early");

  AST_ILLEGAL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> $past(!memRdReq && !memWrReq)) // R1
    else $error("illegal path touched memory");

endmodule

// File: rtl/rmwAtomicUnit.sv
module rmwAtomicUnit
  import rmwAtomicPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_MISALIGN = 6,
  parameter logic [CAUSE_W-1:0] CAUSE_ACCESS   = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  output logic                cmdReady,
  input  logic [31:0]         cmdInstr,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [DATA_W-1:0]   cmdOperand,
  input  logic                cmdPermOk,
  output logic                memRdReq,
  output logic                memWrReq,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrMask,
  input  logic                memRdValid,
  input  logic                memRdErr,
  input  logic [DATA_W-1:0]   memRdData,
  input  logic                memWrReady,
  output logic                doneValid,
  output logic [4:0]          doneRd,
  output logic [DATA_W-1:0]   doneData,
  output logic                illegalPulse,
  output logic                faultValid,
  output logic [CAUSE_W-1:0]  faultCause,
  output logic [ADDR_W-1:0]   faultAddr
);

  dpStrobe_t strobe;
  dpStatus_t status;

  rmwCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdReady     (cmdReady),
    .status       (status),
    .strobe       (strobe),
    .memRdValid   (memRdValid),
    .memRdErr     (memRdErr),
    .memWrReady   (memWrReady),
    .memRdReq     (memRdReq),
    .memWrReq     (memWrReq),
    .doneValid    (doneValid),
    .illegalPulse (illegalPulse),
    .faultValid   (faultValid)
  );

  rmwDatapath #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .CAUSE_W        (CAUSE_W),
    .CAUSE_MISALIGN (CAUSE_MISALIGN),
    .CAUSE_ACCESS   (CAUSE_ACCESS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .status     (status),
    .cmdInstr   (cmdInstr),
    .cmdAddr    (cmdAddr),
    .cmdOperand (cmdOperand),
    .cmdPermOk  (cmdPermOk),
    .memRdData  (memRdData),
    .memWrReq   (memWrReq),
    .memWrReady (memWrReady),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memWrMask  (memWrMask),
    .doneRd     (doneRd),
    .doneData   (doneData),
    .faultCause (faultCause),
    .faultAddr  (faultAddr)
  );

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultCause == CAUSE_ACCESS) || (faultCause == CAUSE_MISALIGN)) // R6
    else $error("unexpected fault cause");

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $past(!memWrReq)) // R7
    else $error("fault after a write");

endmodule

// File: tb/rmwAtomicUnit_bench.sv
module rmwAtomicUnit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [31:0] cmdInstr = '0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdOperand = '0;
  logic        cmdPermOk = 1'b0;
  logic        memRdReq, memWrReq;
  logic [31:0] memAddr, memWrData;
  logic [3:0]  memWrMask;
  logic        memRdValid = 1'b0;
  logic        memRdErr = 1'b0;
  logic [31:0] memRdData = '0;
  logic        memWrReady = 1'b0;
  logic        doneValid;
  logic [4:0]  doneRd;
  logic [31:0] doneData;
  logic        illegalPulse, faultValid;
  logic [4:0]  faultCause;
  logic [31:0] faultAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmwAtomicUnit u_rmwAtomicUnit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdInstr(cmdInstr), .cmdAddr(cmdAddr), .cmdOperand(cmdOperand),
    .cmdPermOk(cmdPermOk), .memRdReq(memRdReq), .memWrReq(memWrReq),
    .memAddr(memAddr), .memWrData(memWrData), .memWrMask(memWrMask),
    .memRdValid(memRdValid), .memRdErr(memRdErr), .memRdData(memRdData),
    .memWrReady(memWrReady), .doneValid(doneValid), .doneRd(doneRd),
    .doneData(doneData), .illegalPulse(illegalPulse), .faultValid(faultValid),
    .faultCause(faultCause), .faultAddr(faultAddr)
  );

  // op code, memory word, operand, expected stored word
  localparam logic [4:0] VEC_OP [NVEC] = '{
    5'b00000, 5'b00000, 5'b00001, 5'b00100, 5'b01100, 5'b01000, 5'b10000,
    5'b10100, 5'b11000, 5'b11100, 5'b10000, 5'b10100, 5'b11000 };
  localparam logic [31:0] VEC_MEM [NVEC] = '{
    32'h0000_0005, 32'hFFFF_FFFF, 32'h1234_5678, 32'hF0F0_F0F0, 32'hF0F0_F0F0,
    32'hF0F0_F0F0, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFE,
    32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000 };
  localparam logic [31:0] VEC_RS2 [NVEC] = '{
    32'h0000_0003, 32'h0000_0002, 32'hDEAD_BEEF, 32'hFF00_FF00, 32'hFF00_FF00,
    32'hFF00_FF00, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0001,
    32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF };
  localparam logic [31:0] VEC_NEW [NVEC] = '{
    32'h0000_0008, 32'h0000_0001, 32'hDEAD_BEEF, 32'h0FF0_0FF0, 32'hF000_F000,
    32'hFFF0_FFF0, 32'hFFFF_FFFE, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFE,
    32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF };

  int checks = 0;
  int fails = 0;
  logic [31:0] mem [16];

  logic        gotDone, gotIllegal, gotFault, finished;
  logic [31:0] outData, outAddr;
  logic [4:0]  outRd, outCause;
  int          rdSeen, wrSeen;
  logic        readyBad, addrBad, maskBad, afterReady, afterPulse;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkInstr(input logic [4:0] op, input logic [2:0] f3,
                                          input logic [4:0] rd, input logic [6:0] opc);
    return {op, 2'b00, 5'd7, 5'd6, f3, rd, opc};
  endfunction

  task automatic runOp(input logic [31:0] instr, input logic [31:0] addr,
                       input logic [31:0] operand, input logic perm,
                       input logic injErr, input int lat);
    int rdCnt;
    int wrCnt;
    gotDone = 0; gotIllegal = 0; gotFault = 0; finished = 0;
    rdSeen = 0; wrSeen = 0; readyBad = 0; addrBad = 0; maskBad = 0;
    rdCnt = 0; wrCnt = 0;
    @(negedge clk);
    if (!cmdReady) readyBad = 1;
    cmdValid = 1; cmdInstr = instr; cmdAddr = addr; cmdOperand = operand; cmdPermOk = perm;
    @(negedge clk);
    cmdValid = 0; cmdPermOk = 0; cmdInstr = '0; cmdOperand = '0;
    for (int k = 0; k < 60 && !finished; k++) begin
      if (k > 0) @(negedge clk);
      memRdValid = 0; memRdErr = 0; memWrReady = 0;
      if (cmdReady) readyBad = 1;
      if (memRdReq) begin
        rdSeen++;
        if (memAddr !== addr) addrBad = 1;
        if (rdCnt >= lat) begin
          if (injErr) memRdErr = 1;
          else begin memRdValid = 1; memRdData = mem[addr[5:2]]; end
        end
        rdCnt++;
      end
      if (memWrReq) begin
        wrSeen++;
        if (memAddr !== addr) addrBad = 1;
        if (memWrMask !== 4'hF) maskBad = 1;
        if (wrCnt >= lat) begin memWrReady = 1; mem[addr[5:2]] = memWrData; end
        wrCnt++;
      end
      if (doneValid || illegalPulse || faultValid) begin
        finished = 1;
        gotDone = doneValid; gotIllegal = illegalPulse; gotFault = faultValid;
        outData = doneData; outRd = doneRd; outCause = faultCause; outAddr = faultAddr;
      end
    end
    check(finished, "R9 outcome within timeout", {31'd0, finished}, 32'd1);
    @(negedge clk);
    memRdValid = 0; memRdErr = 0; memWrReady = 0;
    afterReady = cmdReady;
    afterPulse = doneValid | illegalPulse | faultValid;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + i;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(cmdReady === 1'b1, "R10 ready in reset", {31'd0, cmdReady}, 32'd1);
    check({memRdReq, memWrReq, doneValid, illegalPulse, faultValid} === 5'b0,
          "R10 quiet in reset", {27'd0, memRdReq, memWrReq, doneValid, illegalPulse, faultValid}, 32'd0);
    rstN = 1;
    @(negedge clk);
    check(cmdReady === 1'b1 && !memRdReq && !faultValid, "R10 idle after reset",
          {31'd0, cmdReady}, 32'd1);

    // table of operations, R2 R3 R4 R5 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] a;
      a = i * 4;
      mem[i] = VEC_MEM[i];
      runOp(mkInstr(VEC_OP[i], 3'b010, 5'(i + 1), 7'b0101111), a, VEC_RS2[i], 1'b1, 1'b0, i % 4);
      check(gotDone, "R4 completion", {31'd0, gotDone}, 32'd1);
      check(outData === VEC_MEM[i], "R4 old value returned", outData, VEC_MEM[i]);
      check(outRd === 5'(i + 1), "R4 rd index", {27'd0, outRd}, 32'(i + 1));
      if (VEC_OP[i][4]) check(mem[i] === VEC_NEW[i], "R3 min/max result", mem[i], VEC_NEW[i]);
      else              check(mem[i] === VEC_NEW[i], "R2 stored result", mem[i], VEC_NEW[i]);
      check(!addrBad && !maskBad && wrSeen > 0 && rdSeen > 0, "R5 bus sequence",
            {30'd0, addrBad, maskBad}, 32'd0);
      check(!readyBad && afterReady && !afterPulse, "R9 ready/pulse timing",
            {30'd0, readyBad, afterReady}, 32'd1);
    end

    // R1 unknown op code, address misaligned too: illegal wins
    mem[0] = 32'h1111_1111;
    runOp(mkInstr(5'b11111, 3'b010, 5'd3, 7'b0101111), 32'h2, 32'h5, 1'b1, 1'b0, 0);
    check(gotIllegal && !gotDone && !gotFault, "R1 illegal op code",
          {29'd0, gotIllegal, gotDone, gotFault}, 32'd4);
    check(rdSeen == 0 && wrSeen == 0, "R1 no memory access", 32'(rdSeen + wrSeen), 32'd0);
    check(mem[0] === 32'h1111_1111, "R1 memory unchanged", mem[0], 32'h1111_1111);

    // R1 reserved op code 00010
    runOp(mkInstr(5'b00010, 3'b010, 5'd3, 7'b0101111), 32'h4, 32'h5, 1'b1, 1'b0, 0);
    check(gotIllegal && rdSeen == 0, "R1 reserved code", {31'd0, gotIllegal}, 32'd1);

    // R1 width field not word
    runOp(mkInstr(5'b00000, 3'b011, 5'd3, 7'b0101111), 32'h4, 32'h5, 1'b1, 1'b0, 0);
    check(gotIllegal && rdSeen == 0, "R1 non-word width", {31'd0, gotIllegal}, 32'd1);

    // R1 wrong opcode
    runOp(mkInstr(5'b00000, 3'b010, 5'd3, 7'b0100011), 32'h4, 32'h5, 1'b1, 1'b0, 0);
    check(gotIllegal && rdSeen == 0, "R1 other opcode", {31'd0, gotIllegal}, 32'd1);

    // R8 misaligned with permission denied: misaligned wins
    runOp(mkInstr(5'b00000, 3'b010, 5'd3, 7'b0101111), 32'h22, 32'h5, 1'b0, 1'b0, 0);
    check(gotFault && outCause === 5'd6, "R8 misaligned cause", {27'd0, outCause}, 32'd6);
    check(outAddr === 32'h22 && rdSeen == 0 && !gotDone, "R8 address, no access", outAddr, 32'h22);

    // R6 permission denied
    mem[14] = 32'h5A5A_5A5A;
    runOp(mkInstr(5'b00001, 3'b010, 5'd9, 7'b0101111), 32'h38, 32'h5, 1'b0, 1'b0, 0);
    check(gotFault && outCause === 5'd15, "R6 permission cause", {27'd0, outCause}, 32'd15);
    check(outAddr === 32'h38, "R6 fault address", outAddr, 32'h38);
    check(rdSeen == 0 && wrSeen == 0 && mem[14] === 32'h5A5A_5A5A, "R6 no access",
          32'(rdSeen + wrSeen), 32'd0);

    // R7 read error after latency
    mem[13] = 32'hA5A5_A5A5;
    runOp(mkInstr(5'b00001, 3'b010, 5'd9, 7'b0101111), 32'h34, 32'h5, 1'b1, 1'b1, 2);
    check(gotFault && outCause === 5'd15 && !gotDone, "R7 read error cause",
          {27'd0, outCause}, 32'd15);
    check(outAddr === 32'h34, "R7 fault address", outAddr, 32'h34);
    check(rdSeen > 0 && wrSeen == 0 && mem[13] === 32'hA5A5_A5A5, "R7 no write",
          32'(wrSeen), 32'd0);
    check(afterReady, "R9 ready after fault", {31'd0, afterReady}, 32'd1);

    // R4 a normal op still works after faults
    mem[15] = 32'd40;
    runOp(mkInstr(5'b00000, 3'b010, 5'd31, 7'b0101111), 32'h3C, 32'd2, 1'b1, 1'b0, 0);
    check(gotDone && outData === 32'd40 && outRd === 5'd31, "R4 recovery", outData, 32'd40);
    check(mem[15] === 32'd42, "R2 add after recovery", mem[15], 32'd42);

    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule